// File: doc/BRIEF.md
# Double-Buffered DMA Channel Sequencer

This block sequences one DMA channel that moves data between memory and a peripheral using two buffer slots. It records whether the channel is parked, waiting for a buffer, moving data from one buffer, or moving data with a second buffer already queued behind the first. Software supplies each buffer by writing a base address. The datapath reports each finished buffer with a buffer-end pulse. The block answers with a transfer-active flag, a buffer-select bit that points the address logic at one of two base registers, and an interrupt request. It also keeps a sticky error flag.

The bus master, the address counters and the register file sit outside the block. They appear here only as single-cycle strobes. Every output is registered or decoded from the registered state, so all responses show one clock after the stimulus. The asynchronous active-low reset is released through a synchronizer.

Top module: `dmab_ctrl`

## Requirements
- R1: After reset the state output is 0 (parked), and the interrupt, error flag, buffer-select and transfer-active outputs are all 0. The state codes are parked=0, waiting=1, running=2, queued=3.
- R2: An enable pulse in the parked state moves the channel to waiting on the next clock. Enable has no effect in any other state.
- R3: A base-address write moves waiting to running, and moves running to queued. A base-address write in the parked or queued state has no effect.
- R4: A buffer-end in running, with no base-address write in the same cycle, moves the channel to waiting and raises the interrupt. A buffer-end in queued, with no base-address write in the same cycle, moves the channel to running and raises the interrupt.
- R5: A base-address write that is accepted in waiting or running clears the interrupt.
- R6: A disable pulse returns the channel from any state to parked on the next clock and clears the interrupt and buffer-select. Disable takes priority over every other input, and the interrupt is never high while the channel is parked.
- R7: An error or abort outside the parked state forces waiting, sets the sticky error flag and raises the interrupt. This takes priority over base-address writes and buffer-ends, and the buffer-select bit does not change. The error flag survives disable and clears only on an enable accepted in parked. Error and abort have no effect while the channel is parked.
- R8: Buffer-select toggles on every buffer-end accepted in running or queued. It holds its value otherwise, except when disable clears it.
- R9: Transfer-active is 1 exactly when the state is running or queued.
- R10: A buffer-end and a base-address write in the same cycle leave running or queued unchanged. In that case the buffer-select bit toggles and the interrupt is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable pulse |
| dis_i | input | 1 | Disable pulse |
| base_wr_i | input | 1 | Base-address write strobe |
| buf_end_i | input | 1 | Current buffer finished |
| err_i | input | 1 | Transfer error |
| abort_i | input | 1 | Bus abort |
| state_o | output | 2 | Current state code |
| xfer_active_o | output | 1 | Channel moving data |
| buf_sel_o | output | 1 | Selects base register 0 or 1 |
| irq_o | output | 1 | Interrupt request |
| err_o | output | 1 | Sticky error flag |

## Verification
The bench targets the cases where two events arrive in the same cycle.

- A buffer-end together with a base-address write must hold running or queued. A design that handled only one of the two strobes would drop to waiting or lose the queued buffer.
- Error together with a buffer-end must leave buffer-select alone. A design that let the buffer-end through would skew the address alternation.
- Disable together with enable or error must park the channel. A design with the priority inverted would keep running or raise a spurious interrupt.

The bench also writes a base address in the queued state, where there is no free slot. It then confirms that the error flag survives disable, which a design that cleared it too eagerly would lose.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
  localparam int ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_PARK  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_QUEUE = 2'd3
  } dmab_state_e;

  typedef struct packed {
    logic irq_set;
    logic irq_clr;
    logic sel_tgl;
    logic err_set;
    logic err_clr;
    logic hard_clr;
  } dmab_evt_t;
endpackage

// File: rtl/dmab_rst_sync.sv
module dmab_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/dmab_next.sv
module dmab_next
  import dmab_pkg::*;
(
  input  dmab_state_e cur_i,
  input  logic        en_i,
  input  logic        dis_i,
  input  logic        base_wr_i,
  input  logic        buf_end_i,
  input  logic        fault_i,
  output dmab_state_e nxt_o,
  output dmab_evt_t   evt_o
);
  always_comb begin
    nxt_o = cur_i;
    evt_o = '0;
    if (dis_i) begin
      nxt_o          = ST_PARK;
      evt_o.hard_clr = 1'b1;
    end else if (cur_i == ST_PARK) begin
      if (en_i) begin
        nxt_o         = ST_WAIT;
        evt_o.err_clr = 1'b1;
      end
    end else if (fault_i) begin
      nxt_o         = ST_WAIT;
      evt_o.err_set = 1'b1;
      evt_o.irq_set = 1'b1;
    end else begin
      unique case (cur_i)
        ST_WAIT: begin
          if (base_wr_i) begin
            nxt_o         = ST_RUN;
            evt_o.irq_clr = 1'b1;
          end
        end
        ST_RUN: begin
          if (buf_end_i) begin
            evt_o.sel_tgl = 1'b1;
            if (base_wr_i) begin
              evt_o.irq_clr = 1'b1;
            end else begin
              nxt_o         = ST_WAIT;
              evt_o.irq_set = 1'b1;
            end
          end else if (base_wr_i) begin
            nxt_o         = ST_QUEUE;
            evt_o.irq_clr = 1'b1;
          end
        end
        ST_QUEUE: begin
          if (buf_end_i) begin
            evt_o.sel_tgl = 1'b1;
            if (base_wr_i) begin
              evt_o.irq_clr = 1'b1;
            end else begin
              nxt_o         = ST_RUN;
              evt_o.irq_set = 1'b1;
            end
          end
        end
        default: nxt_o = cur_i;
      endcase
    end
  end
endmodule

// File: rtl/dmab_flags.sv
module dmab_flags
  import dmab_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  dmab_evt_t evt_i,
  output logic      irq_o,
  output logic      err_o,
  output logic      sel_o
);
  logic irq_q, err_q, sel_q;
  logic irq_en, err_en, sel_en;
  logic irq_d, err_d, sel_d;

  always_comb begin
    irq_en = evt_i.hard_clr | evt_i.irq_set | evt_i.irq_clr;
    irq_d  = evt_i.irq_set & ~evt_i.hard_clr;
    err_en = evt_i.err_set | evt_i.err_clr;
    err_d  = evt_i.err_set;
    sel_en = evt_i.hard_clr | evt_i.sel_tgl;
    sel_d  = ~sel_q & ~evt_i.hard_clr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      if (irq_en) irq_q <= irq_d;
      if (err_en) err_q <= err_d;
      if (sel_en) sel_q <= sel_d;
    end
  end

  assign irq_o = irq_q;
  assign err_o = err_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/dmab_ctrl.sv
module dmab_ctrl
  import dmab_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            dis_i,
  input  logic            base_wr_i,
  input  logic            buf_end_i,
  input  logic            err_i,
  input  logic            abort_i,
  output logic [ST_W-1:0] state_o,
  output logic            xfer_active_o,
  output logic            buf_sel_o,
  output logic            irq_o,
  output logic            err_o
);
  logic        rst_q_n;
  dmab_state_e state_q, state_d;
  dmab_evt_t   evt;

  dmab_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_q_n)
  );

  dmab_next u_next (
    .cur_i     (state_q),
    .en_i      (en_i),
    .dis_i     (dis_i),
    .base_wr_i (base_wr_i),
    .buf_end_i (buf_end_i),
    .fault_i   (err_i | abort_i),
    .nxt_o     (state_d),
    .evt_o     (evt)
  );

  always_ff @(posedge clk_i or negedge rst_q_n) begin
    if (!rst_q_n) state_q <= ST_PARK;
    else          state_q <= state_d;
  end

  dmab_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_q_n),
    .evt_i  (evt),
    .irq_o  (irq_o),
    .err_o  (err_o),
    .sel_o  (buf_sel_o)
  );

  assign state_o       = state_q;
  assign xfer_active_o = (state_q == ST_RUN) || (state_q == ST_QUEUE);
endmodule

// File: rtl/dmab_ctrl_chk.sv
module dmab_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       dis,
  input logic       bw,
  input logic       be,
  input logic       er,
  input logic       ab,
  input logic [1:0] st,
  input logic       sel,
  input logic       irq,
  input logic       errf
);
  AST_DIS_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> (st == 2'd0 && !irq && !sel)); // R6
  AST_PARK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> !irq); // R6
  AST_EN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && en && !dis) |=> (st == 2'd1 && !errf)); // R2
  AST_FAULT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0 && (er || ab) && !dis) |=> (st == 2'd1 && irq && errf && $stable(sel))); // R7
  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!be && !dis) |=> $stable(sel)); // R8
  AST_RUN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && be && !bw && !er && !ab && !dis) |=> (st == 2'd1 && irq)); // R4
  AST_QUEUE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && bw && !be && !er && !ab && !dis) |=> (st == 2'd3)); // R3
endmodule

bind dmab_ctrl dmab_ctrl_chk u_chk (
  .clk  (clk_i),
  .rst_n(rst_q_n),
  .en   (en_i),
  .dis  (dis_i),
  .bw   (base_wr_i),
  .be   (buf_end_i),
  .er   (err_i),
  .ab   (abort_i),
  .st   (state_o),
  .sel  (buf_sel_o),
  .irq  (irq_o),
  .errf (err_o)
);

// File: tb/sim_dmab_ctrl.sv
`timescale 1ns/1ps
module sim_dmab_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, dis = 0, bw = 0, be = 0, er = 0, ab = 0;
  logic [1:0] st;
  logic act, sel, irq, errf;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    int         due;
    logic [1:0] st;
    logic       irq, errf, sel;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dmab_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .dis_i(dis), .base_wr_i(bw),
    .buf_end_i(be), .err_i(er), .abort_i(ab), .state_o(st),
    .xfer_active_o(act), .buf_sel_o(sel), .irq_o(irq), .err_o(errf)
  );

  task automatic cmp(input exp_t e);
    logic exp_act;
    exp_act = (e.st == 2'd2) || (e.st == 2'd3);
    n_chk++;
    if (st !== e.st || irq !== e.irq || errf !== e.errf || sel !== e.sel || act !== exp_act) begin
      n_fail++;
      $display("FAIL %s: st/irq/err/sel/act got %0d/%b/%b/%b/%b exp %0d/%b/%b/%b/%b (R9 act)",
               e.tag, st, irq, errf, sel, act, e.st, e.irq, e.errf, e.sel, exp_act);
    end
  endtask

  task automatic step(input logic ien, idis, ibw, ibe, ier, iab,
                      input logic [1:0] xst, input logic xirq, xerr, xsel, input string tag);
    exp_t e;
    @(negedge clk);
    en = ien; dis = idis; bw = ibw; be = ibe; er = ier; ab = iab;
    e.due = cyc + 1; e.st = xst; e.irq = xirq; e.errf = xerr; e.sel = xsel; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #0.5;
      while (q.size() > 0 && q[0].due <= cyc) cmp(q.pop_front());
    end
  end

  initial begin : driver
    exp_t r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    r.st = 0; r.irq = 0; r.errf = 0; r.sel = 0; r.tag = "R1 reset";
    cmp(r);
    //   en dis bw be er ab  st irq err sel
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 quiet");
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R3 bw parked");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R7 err parked");
    step(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R2 enable");
    step(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R2 enable again");
    step(0, 0, 1, 0, 0, 0, 2, 0, 0, 0, "R3 wait->run");
    step(0, 0, 1, 0, 0, 0, 3, 0, 0, 0, "R3 run->queue");
    step(0, 0, 1, 0, 0, 0, 3, 0, 0, 0, "R3 bw queued");
    step(0, 0, 0, 1, 0, 0, 2, 1, 0, 1, "R4 queue->run R8");
    step(0, 0, 1, 0, 0, 0, 3, 0, 0, 1, "R5 bw clears irq");
    step(0, 0, 0, 1, 0, 0, 2, 1, 0, 0, "R4 queue->run again");
    step(0, 0, 0, 1, 0, 0, 1, 1, 0, 1, "R4 run->wait");
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, 1, "R8 sel holds");
    step(0, 0, 1, 0, 0, 0, 2, 0, 0, 1, "R5 wait bw clears");
    step(0, 0, 1, 1, 0, 0, 2, 0, 0, 0, "R10 run be+bw");
    step(0, 0, 1, 0, 0, 0, 3, 0, 0, 0, "R3 to queue");
    step(0, 0, 1, 1, 0, 0, 3, 0, 0, 1, "R10 queue be+bw");
    step(0, 0, 0, 0, 0, 1, 1, 1, 1, 1, "R7 abort");
    step(0, 0, 1, 0, 0, 0, 2, 0, 1, 1, "R7 err sticky");
    step(0, 0, 1, 1, 1, 0, 1, 1, 1, 1, "R7 err beats be");
    step(1, 1, 1, 0, 1, 0, 0, 0, 1, 0, "R6 dis priority");
    step(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R7 en clears err");
    step(0, 0, 1, 0, 0, 0, 2, 0, 0, 0, "R3 run");
    step(0, 0, 0, 1, 0, 0, 1, 1, 0, 1, "R4 run done");
    step(0, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R6 dis over err");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 parked");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule